// File: doc/BRIEF.md
# Biresidue Single-Error Corrector

The block takes a 12-bit data word together with two check fields: the word's residue modulo 7, held in 3 bits, and its residue modulo 15, held in 4 bits. It recomputes both residues from the data as received. From each pair of residues it forms a syndrome, which is the recomputed residue minus the received one, reduced by the same modulus. The pair of syndromes identifies any arithmetic error of the form +2^i or -2^i for i from 0 to 11. Each of these 24 errors gives its own distinct pair. The block removes the error by adding or subtracting 2^i modulo 4096.

The block also classifies each beat with a status flag: corrected, error confined to a check field, or uncorrectable. Data enters on a valid/ready stream. Corrected data and flags leave on a registered valid/ready stream, one cycle after the beat is accepted.

Back-pressure follows a single rule. The input is ready whenever the output register is empty or is being emptied in the same cycle. A beat that is offered while the input is not ready is not taken, and the source may change it freely. An output beat that is not taken stays exactly as it is until the sink takes it.

Top module: `bires_corrector`

## Requirements
- R1: When both syndromes are zero, the block passes the data through unchanged and keeps all three flags low.
- R2: When the syndrome pair equals (2^i mod 7, 2^i mod 15) for some i in 0..11, the output data is (in_data - 2^i) mod 4096 and out_fixed is high.
- R3: When the syndrome pair equals (7 - 2^i mod 7, 15 - 2^i mod 15) for some i in 0..11, the output data is (in_data + 2^i) mod 4096 and out_fixed is high.
- R4: When exactly one syndrome is nonzero, the block passes the data through unchanged and raises out_chk_err.
- R5: When both syndromes are nonzero and the pair matches none of the 24 patterns, the block passes the data through unchanged and raises out_uncorr.
- R6: A received check field of all ones (7 in the mod-7 field, 15 in the mod-15 field) is taken as residue zero.
- R7: At most one of out_fixed, out_chk_err and out_uncorr is high on any valid output beat.
- R8: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the output data and flags hold their values.
- R9: A beat accepted in one cycle is presented on the output in the next cycle. If the output beat is taken and no new beat is accepted, out_valid falls.
- R10: During reset, and on the first cycle after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 12 | Received data word |
| in_chk_a | input | 3 | Received residue modulo 7 |
| in_chk_b | input | 4 | Received residue modulo 15 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink takes the output beat |
| out_data | output | 12 | Corrected data |
| out_fixed | output | 1 | A ±2^i error was removed |
| out_chk_err | output | 1 | Error confined to one check field |
| out_uncorr | output | 1 | Error pattern not correctable |

## Verification
Two events can fall in the same cycle: the hand-off of the held output beat to the sink, and the acceptance of a new beat that replaces it. If that cycle is mishandled, the block either loses a beat or shows one twice. The bench provokes the collision by driving out_ready and in_valid at random, each independently, over thousands of cycles that mix clean, corrected, check-field and uncorrectable beats. A behavioural model works out from the requirements which beat must be on the output in every cycle. The bench compares the output with that model on every clock, and also compares in_ready with the model's ready rule in every cycle.

// File: rtl/bires_pkg.sv
package bires_pkg;
  localparam int DATA_W = 12;
  localparam int CHK_A_W = 3;
  localparam int CHK_B_W = 4;

  typedef enum logic [1:0] {
    OUT_CLEAN  = 2'd0,
    OUT_FIXED  = 2'd1,
    OUT_FIELD  = 2'd2,
    OUT_UNCORR = 2'd3
  } outcome_e;

  typedef struct packed {
    logic fixed;
    logic chk_err;
    logic uncorr;
  } flags_t;

  function automatic flags_t outcome_flags(outcome_e o);
    flags_t f;
    f.fixed   = (o == OUT_FIXED);
    f.chk_err = (o == OUT_FIELD);
    f.uncorr  = (o == OUT_UNCORR);
    return f;
  endfunction
endpackage

// File: rtl/residue_fold.sv
module residue_fold #(
  parameter int W = 12,
  parameter int M = 3
) (
  input  logic [W-1:0] val,
  output logic [M-1:0] res
);
  localparam int NCH = (W + M - 1) / M;
  localparam int PW  = NCH * M;

  logic [PW-1:0] padded;
  logic [M-1:0]  acc;
  logic [M:0]    sum;

  assign padded = PW'(val);

  // end-around-carry accumulation of M-bit chunks
  always_comb begin
    acc = '0;
    sum = '0;
    for (int k = 0; k < NCH; k++) begin
      sum = {1'b0, acc} + {1'b0, padded[k*M +: M]};
      acc = sum[M-1:0] + M'(sum[M]);
    end
    res = (&acc) ? '0 : acc;
  end
endmodule

// File: rtl/bires_locate.sv
module bires_locate #(
  parameter int DW = 12,
  parameter int AW = 3,
  parameter int BW = 4
) (
  input  logic [AW-1:0] syn_a,
  input  logic [BW-1:0] syn_b,
  output logic [DW-1:0] pos_hit,
  output logic [DW-1:0] neg_hit
);
  localparam int MOD_A = (1 << AW) - 1;
  localparam int MOD_B = (1 << BW) - 1;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam int PA = (1 << (i % AW)) % MOD_A;
    localparam int PB = (1 << (i % BW)) % MOD_B;
    localparam int NA = MOD_A - PA;
    localparam int NB = MOD_B - PB;
    assign pos_hit[i] = (syn_a == AW'(PA)) && (syn_b == BW'(PB));
    assign neg_hit[i] = (syn_a == AW'(NA)) && (syn_b == BW'(NB));
  end
endmodule

// File: rtl/bires_corrector.sv
module bires_corrector
  import bires_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = CHK_A_W,
  parameter int BW = CHK_B_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] in_chk_a,
  input  logic [BW-1:0] in_chk_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_fixed,
  output logic          out_chk_err,
  output logic          out_uncorr
);
  logic [AW-1:0] calc_a, syn_a;
  logic [BW-1:0] calc_b, syn_b;
  logic [DW-1:0] pos_hit, neg_hit, mag, fixed_data;
  outcome_e      outcome;
  flags_t        nxt_flags;
  logic          take;

  residue_fold #(.W(DW), .M(AW)) u_res_a (.val(in_data), .res(calc_a));
  residue_fold #(.W(DW), .M(BW)) u_res_b (.val(in_data), .res(calc_b));

  // calc + ~recv == calc - recv modulo 2^M-1
  residue_fold #(.W(2*AW), .M(AW)) u_syn_a (.val({calc_a, ~in_chk_a}), .res(syn_a));
  residue_fold #(.W(2*BW), .M(BW)) u_syn_b (.val({calc_b, ~in_chk_b}), .res(syn_b));

  bires_locate #(.DW(DW), .AW(AW), .BW(BW)) u_loc (
    .syn_a(syn_a), .syn_b(syn_b), .pos_hit(pos_hit), .neg_hit(neg_hit)
  );

  always_comb begin
    mag = '0;
    for (int i = 0; i < DW; i++)
      if (pos_hit[i] || neg_hit[i]) mag = mag | (DW'(1) << i);
  end

  always_comb begin
    fixed_data = in_data;
    outcome    = OUT_CLEAN;
    if (syn_a == '0 && syn_b == '0) begin
      outcome = OUT_CLEAN;
    end else if (syn_a == '0 || syn_b == '0) begin
      outcome = OUT_FIELD;
    end else if (|pos_hit) begin
      outcome    = OUT_FIXED;
      fixed_data = in_data - mag;
    end else if (|neg_hit) begin
      outcome    = OUT_FIXED;
      fixed_data = in_data + mag;
    end else begin
      outcome = OUT_UNCORR;
    end
    nxt_flags = outcome_flags(outcome);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data    <= '0;
      out_fixed   <= 1'b0;
      out_chk_err <= 1'b0;
      out_uncorr  <= 1'b0;
    end else if (take) begin
      out_data    <= fixed_data;
      out_fixed   <= nxt_flags.fixed;
      out_chk_err <= nxt_flags.chk_err;
      out_uncorr  <= nxt_flags.uncorr;
    end
  end
endmodule

// File: rtl/bires_corrector_chk.sv
module bires_corrector_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_fixed,
  input logic          out_chk_err,
  input logic          out_uncorr
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_fixed, out_chk_err, out_uncorr})); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_fixed)
      && $stable(out_chk_err) && $stable(out_uncorr)); // R8

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9

  AST_PASS_UNLESS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_fixed || out_data == $past(in_data)); // R4

  AST_FIX_POWER_OF_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_fixed
      || $countones(DW'(out_data - $past(in_data))) == 1
      || $countones(DW'($past(in_data) - out_data)) == 1); // R2
endmodule

bind bires_corrector bires_corrector_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_fixed(out_fixed), .out_chk_err(out_chk_err),
  .out_uncorr(out_uncorr)
);

// File: tb/bires_corrector_tb.sv
module bires_corrector_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [11:0] in_data, out_data;
  logic [2:0]  in_chk_a;
  logic [3:0]  in_chk_b;
  logic        out_fixed, out_chk_err, out_uncorr;

  bires_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chk_a(in_chk_a), .in_chk_b(in_chk_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_fixed(out_fixed), .out_chk_err(out_chk_err), .out_uncorr(out_uncorr)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  bit    m_valid = 0;
  int    m_data = 0;
  bit    m_fix = 0, m_chk = 0, m_unc = 0;
  string m_tag = "R1";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model of one accepted beat
  task automatic model(input int d, input int ra, input int rb, output int od,
                       output bit f, output bit c, output bit u, output string tag);
    int rna, rnb, sa, sb;
    rna = (ra == 7) ? 0 : ra;
    rnb = (rb == 15) ? 0 : rb;
    sa = ((d % 7) - rna + 7) % 7;
    sb = ((d % 15) - rnb + 15) % 15;
    od = d; f = 0; c = 0; u = 0; tag = "R1";
    if (sa == 0 && sb == 0) begin
      tag = "R1";
    end else if (sa == 0 || sb == 0) begin
      c = 1; tag = "R4";
    end else begin
      for (int i = 0; i < 12; i++) begin
        if (!f && sa == (1 << i) % 7 && sb == (1 << i) % 15) begin
          od = (d - (1 << i) + 4096) % 4096; f = 1; tag = "R2";
        end else if (!f && sa == 7 - (1 << i) % 7 && sb == 15 - (1 << i) % 15) begin
          od = (d + (1 << i)) % 4096; f = 1; tag = "R3";
        end
      end
      if (!f) begin u = 1; tag = "R5"; end
    end
    if (ra == 7 || rb == 15) tag = {tag, "/R6"};
  endtask

  task automatic gen_beat();
    int cls, d0, d, ra, rb, i;
    cls = $urandom_range(0, 5);
    d0 = $urandom_range(0, 4095);
    i = $urandom_range(0, 11);
    if (cls == 4) d0 = 105 * $urandom_range(0, 38);
    ra = d0 % 7; rb = d0 % 15; d = d0;
    case (cls)
      1: d = (d0 + (1 << i)) % 4096;
      2: d = (d0 - (1 << i) + 4096) % 4096;
      3: if ($urandom_range(0, 1) == 1) ra = (ra + $urandom_range(1, 6)) % 7;
         else rb = (rb + $urandom_range(1, 14)) % 15;
      4: begin
        ra = 7; rb = 15;
        if ($urandom_range(0, 1) == 1) d = (d0 + (1 << i)) % 4096;
      end
      5: begin ra = $urandom_range(0, 7); rb = $urandom_range(0, 15); end
      default: ;
    endcase
    in_data = 12'(d); in_chk_a = 3'(ra); in_chk_b = 4'(rb);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_data = '0; in_chk_a = '0; in_chk_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit acc;
      int od;
      bit f, c, u;
      string tg;
      if (cyc > 0) @(negedge clk);
      // compare with the model (R9 for presence, beat tag for contents)
      check(out_valid == m_valid, "R9", "out_valid", int'(out_valid), int'(m_valid));
      if (m_valid && out_valid) begin
        check(int'(out_data) == m_data, m_tag, "out_data", int'(out_data), m_data);
        check({out_fixed, out_chk_err, out_uncorr} == {m_fix, m_chk, m_unc}, m_tag,
              "flags", int'({out_fixed, out_chk_err, out_uncorr}), int'({m_fix, m_chk, m_unc}));
        check($countones({out_fixed, out_chk_err, out_uncorr}) <= 1, "R7", "flag count",
              $countones({out_fixed, out_chk_err, out_uncorr}), 1);
      end
      // drive next cycle; stalls come in bursts in the middle third
      in_valid = ($urandom_range(0, 9) < 7);
      if (cyc > 2000 && cyc < 4000) out_ready = ($urandom_range(0, 9) < 3);
      else out_ready = ($urandom_range(0, 9) < 8);
      if (in_valid) gen_beat();
      else begin in_data = 12'($urandom); in_chk_a = 3'($urandom); in_chk_b = 4'($urandom); end
      #1;
      check(in_ready == (!m_valid || out_ready), "R8", "in_ready",
            int'(in_ready), int'(!m_valid || out_ready));
      acc = in_valid && (!m_valid || out_ready);
      if (acc) begin
        model(int'(in_data), int'(in_chk_a), int'(in_chk_b), od, f, c, u, tg);
        m_valid = 1; m_data = od; m_fix = f; m_chk = c; m_unc = u; m_tag = tg;
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule